// File: doc/BRIEF.md
# Multi-Format Serial Master Engine

This block is a synchronous serial master that moves one character per transfer. It drives a serial clock and a data-out line and captures a data-in line, and for the duration of a transfer it pulls one of several active-low chip-select outputs low. The received character comes back right-aligned with a one-cycle completion pulse and a sticky parity-error flag.

Four format words are preloaded through a small write port. Each one holds a clock divider, a character length from 2 to 16 bits, clock polarity and phase, a parity enable, enables for a chip-select setup and hold delay, and the bit order. A start request picks one format by a 2-bit index, one chip select and a transmit word. The setup and hold delays are counts of system clocks taken from one shared delay register.

Top module: `spi_fmt_master`

## Requirements
- R1: After reset `sclk` is 0, `cs_n` is all ones, `busy`, `done` and `par_err` are 0 and `rx_data` is 0.
- R2: A pulse on `fmt_wr` stores `fmt_wr_data` into slot `fmt_wr_idx` of four independent format slots. The field layout is [7:0] divider, [11:8] length minus one, [12] phase, [13] polarity, [14] parity enable, [15] setup enable, [16] hold enable, [17] LSB-first. A start uses the slot named by `start_fmt`, and that slot's contents are latched for the whole transfer.
- R3: Each half period of `sclk` lasts divider+1 system clocks. A transfer of n bit slots gives exactly 2n `sclk` edges. `sclk` rests at the polarity value from the start cycle until the first edge and again after the last edge.
- R4: The character length is the length field plus one, and a field value of 0 is treated as a length of 2. Transmit bits at or above the length are ignored, and received bits at or above the length read as 0.
- R5: With bit [17] clear, the MSB of the character goes out first. With bit [17] set, bit 0 goes out first. Received bits are placed in the same order.
- R6: With phase 0, data-in is sampled on the first edge of each bit slot and data-out changes on the second edge. With phase 1, data-out changes on the first edge and data-in is sampled on the second edge. In both cases `rx_data` equals the character the slave sent.
- R7: With parity enabled, one even-parity bit over the data bits is sent after the last data bit, and the matching received bit is checked. A mismatch sets `par_err` in the cycle after `done`. The flag stays set until `par_err_clr` is pulsed, and a new error in the same cycle takes priority over the clear.
- R8: `dly_wr` loads the setup count from `dly_wr_data[7:0]` and the hold count from `dly_wr_data[15:8]`. A start sampled at clock edge t gives `done` after edge t + S + 2n(divider+1) + H. S and H are the counts when their enables are set and 0 otherwise; a zero count adds no delay.
- R9: `cs_n[start_cs]` is low from the cycle after the start until `done`, and no other select is ever low. A `start_cs` value of 6 or 7 asserts no select.
- R10: `done` is high for exactly one cycle per transfer, `rx_data` is valid from then until the next start, and `busy` is high from the cycle after the start through the `done` cycle.
- R11: A start request while `busy` is high is ignored: the running transfer keeps its select, format and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_wr | input | 1 | Format slot write strobe |
| fmt_wr_idx | input | 2 | Format slot to write |
| fmt_wr_data | input | 18 | Format word (layout in R2) |
| dly_wr | input | 1 | Delay register write strobe |
| dly_wr_data | input | 16 | Hold count [15:8], setup count [7:0] |
| start | input | 1 | Transfer request |
| start_fmt | input | 2 | Format slot used by the request |
| start_cs | input | 3 | Chip select used by the request |
| tx_data | input | 16 | Character to send, right-aligned |
| miso | input | 1 | Serial data in |
| par_err_clr | input | 1 | Clears the parity-error flag |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 6 | Active-low chip selects |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_data | output | 16 | Received character, right-aligned |
| par_err | output | 1 | Sticky parity-error flag |

## Verification
The assertions assume that the format slots and the delay register are not rewritten while `busy` is high. They also assume that the slave changes `miso` only after an `sclk` edge, so each value is stable at the next sampling edge. The stimulus writes formats and delays only between transfers. The modelled slave updates `miso` right after each clock edge it sees, and the sweep varies divider, length, order, mode, parity, delays and chip select on every transfer while computing durations, bit streams and results arithmetically.

// File: rtl/spi_fmt_pkg.sv
package spi_fmt_pkg;

  localparam int DATA_W = 16;
  localparam int LEN_W  = $clog2(DATA_W);
  localparam int DIV_W  = 8;
  localparam int DLY_W  = 8;
  localparam int FMT_W  = DIV_W + LEN_W + 6;

  // Packed format word; the field order fixes the bit layout seen by software.
  typedef struct packed {
    logic             lsb_first;
    logic             hold_en;
    logic             setup_en;
    logic             par_en;
    logic             cpol;
    logic             cpha;
    logic [LEN_W-1:0] len_m1;
    logic [DIV_W-1:0] div;
  } fmt_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_XFER,
    ST_HOLD,
    ST_FIN
  } state_t;

endpackage

// File: rtl/spi_fmt_regs.sv
module spi_fmt_regs
  import spi_fmt_pkg::*;
#(
  parameter int NUM_FMT = 4,
  parameter int IDX_W   = $clog2(NUM_FMT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [FMT_W-1:0]   wr_data,
  input  logic               dly_wr,
  input  logic [2*DLY_W-1:0] dly_data,
  input  logic [IDX_W-1:0]   rd_idx,
  output fmt_t               rd_fmt,
  output logic [DLY_W-1:0]   su_cnt,
  output logic [DLY_W-1:0]   ho_cnt
);

  fmt_t bank [NUM_FMT];

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_slot
    fmt_t slot_q;
    fmt_t slot_d;

    always_comb begin
      slot_d = slot_q;
      if (wr_en && (wr_idx == IDX_W'(g))) begin
        slot_d = fmt_t'(wr_data);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q <= '0;
      else        slot_q <= slot_d;
    end

    assign bank[g] = slot_q;
  end

  assign rd_fmt = bank[rd_idx];

  logic [2*DLY_W-1:0] dly_q;
  logic [2*DLY_W-1:0] dly_d;

  always_comb begin
    dly_d = dly_q;
    if (dly_wr) dly_d = dly_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dly_q <= '0;
    else        dly_q <= dly_d;
  end

  assign su_cnt = dly_q[DLY_W-1:0];
  assign ho_cnt = dly_q[2*DLY_W-1:DLY_W];

endmodule

// File: rtl/spi_fmt_baud.sv
module spi_fmt_baud
  import spi_fmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] hc_q;
  logic [DIV_W-1:0] hc_d;

  always_comb begin
    tick = run && (hc_q == div);
    if (!run)      hc_d = '0;
    else if (tick) hc_d = '0;
    else           hc_d = hc_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hc_q <= '0;
    else        hc_q <= hc_d;
  end

  // R3
  hc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (hc_q <= div));

endmodule

// File: rtl/spi_fmt_shift.sv
module spi_fmt_shift
  import spi_fmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic              samp,
  input  logic [DATA_W-1:0] tx_data,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic              lsb_first,
  input  logic              par_en,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_word,
  output logic              rx_par_bad
);

  localparam int IDX_W = LEN_W + 1;

  logic [DATA_W-1:0] tx_q, tx_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic [IDX_W-1:0]  bidx_q, bidx_d;
  logic              pbit_q, pbit_d;
  logic [DATA_W-1:0] mask;
  logic [LEN_W-1:0]  pos;
  logic              in_par;

  always_comb begin
    mask   = ~({DATA_W{1'b1}} << ({1'b0, len_m1} + IDX_W'(1)));
    in_par = bidx_q > {1'b0, len_m1};
    pos    = lsb_first ? bidx_q[LEN_W-1:0] : (len_m1 - bidx_q[LEN_W-1:0]);
    mosi   = in_par ? ^(tx_q & mask) : tx_q[pos];

    tx_d   = tx_q;
    rx_d   = rx_q;
    bidx_d = bidx_q;
    pbit_d = pbit_q;
    if (load) begin
      tx_d   = tx_data;
      rx_d   = '0;
      bidx_d = '0;
      pbit_d = 1'b0;
    end else begin
      if (samp) begin
        if (in_par) pbit_d   = miso;
        else        rx_d[pos] = miso;
      end
      if (adv) bidx_d = bidx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      bidx_q <= '0;
      pbit_q <= 1'b0;
    end else begin
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      bidx_q <= bidx_d;
      pbit_q <= pbit_d;
    end
  end

  assign rx_word    = rx_q;
  assign rx_par_bad = par_en & ((^rx_q) ^ pbit_q);

  // R4
  bidx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |-> (bidx_q <= ({1'b0, len_m1} + IDX_W'(1))));

endmodule

// File: rtl/spi_fmt_master.sv
module spi_fmt_master
  import spi_fmt_pkg::*;
#(
  parameter  int NUM_FMT = 4,
  parameter  int NUM_CS  = 6,
  localparam int FIDX_W  = $clog2(NUM_FMT),
  localparam int CSEL_W  = $clog2(NUM_CS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fmt_wr,
  input  logic [FIDX_W-1:0]  fmt_wr_idx,
  input  logic [FMT_W-1:0]   fmt_wr_data,
  input  logic               dly_wr,
  input  logic [2*DLY_W-1:0] dly_wr_data,
  input  logic               start,
  input  logic [FIDX_W-1:0]  start_fmt,
  input  logic [CSEL_W-1:0]  start_cs,
  input  logic [DATA_W-1:0]  tx_data,
  input  logic               miso,
  input  logic               par_err_clr,
  output logic               sclk,
  output logic               mosi,
  output logic [NUM_CS-1:0]  cs_n,
  output logic               busy,
  output logic               done,
  output logic [DATA_W-1:0]  rx_data,
  output logic               par_err
);

  localparam int EDGE_W = $clog2(2 * (DATA_W + 1));

  fmt_t              rd_fmt, new_fmt, cur_q, cur_d;
  state_t            st_q, st_d;
  logic [CSEL_W-1:0] cs_q, cs_d;
  logic              sclk_q, sclk_d;
  logic [EDGE_W-1:0] edge_q, edge_d;
  logic [DLY_W-1:0]  cnt_q, cnt_d;
  logic              perr_q, perr_d;
  logic [DLY_W-1:0]  su_cnt, ho_cnt;
  logic [EDGE_W-1:0] nbits;
  logic              tick, adv, samp, load, last_edge, even, sel_on, rx_par_bad;

  spi_fmt_regs #(.NUM_FMT(NUM_FMT)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (fmt_wr),
    .wr_idx   (fmt_wr_idx),
    .wr_data  (fmt_wr_data),
    .dly_wr   (dly_wr),
    .dly_data (dly_wr_data),
    .rd_idx   (start_fmt),
    .rd_fmt   (rd_fmt),
    .su_cnt   (su_cnt),
    .ho_cnt   (ho_cnt)
  );

  spi_fmt_baud u_baud (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (st_q == ST_XFER),
    .div   (cur_q.div),
    .tick  (tick)
  );

  spi_fmt_shift u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .adv        (adv),
    .samp       (samp),
    .tx_data    (tx_data),
    .len_m1     (cur_q.len_m1),
    .lsb_first  (cur_q.lsb_first),
    .par_en     (cur_q.par_en),
    .miso       (miso),
    .mosi       (mosi),
    .rx_word    (rx_data),
    .rx_par_bad (rx_par_bad)
  );

  // Edge bookkeeping: even edges lead a bit slot, odd edges trail it.
  always_comb begin
    nbits     = EDGE_W'(cur_q.len_m1) + EDGE_W'(1) + EDGE_W'(cur_q.par_en);
    last_edge = edge_q == ((nbits << 1) - EDGE_W'(1));
    even      = ~edge_q[0];
    samp      = tick && (cur_q.cpha ? ~even : even);
    adv       = tick && (cur_q.cpha ? (even && (edge_q != '0)) : (~even && ~last_edge));
  end

  // Next-state logic
  always_comb begin
    new_fmt = rd_fmt;
    if (new_fmt.len_m1 == '0) new_fmt.len_m1 = LEN_W'(1);

    load   = (st_q == ST_IDLE) && start;
    st_d   = st_q;
    cur_d  = cur_q;
    cs_d   = cs_q;
    sclk_d = sclk_q;
    edge_d = edge_q;
    cnt_d  = cnt_q;

    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          cur_d  = new_fmt;
          cs_d   = start_cs;
          sclk_d = new_fmt.cpol;
          edge_d = '0;
          cnt_d  = '0;
          st_d   = (new_fmt.setup_en && (su_cnt != '0)) ? ST_SETUP : ST_XFER;
        end
      end
      ST_SETUP: begin
        if (cnt_q == (su_cnt - DLY_W'(1))) begin
          cnt_d = '0;
          st_d  = ST_XFER;
        end else begin
          cnt_d = cnt_q + DLY_W'(1);
        end
      end
      ST_XFER: begin
        if (tick) begin
          sclk_d = ~sclk_q;
          edge_d = edge_q + EDGE_W'(1);
          if (last_edge) begin
            st_d = (cur_q.hold_en && (ho_cnt != '0)) ? ST_HOLD : ST_FIN;
          end
        end
      end
      ST_HOLD: begin
        if (cnt_q == (ho_cnt - DLY_W'(1))) begin
          cnt_d = '0;
          st_d  = ST_FIN;
        end else begin
          cnt_d = cnt_q + DLY_W'(1);
        end
      end
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase

    perr_d = perr_q;
    if ((st_q == ST_FIN) && rx_par_bad) perr_d = 1'b1;
    else if (par_err_clr)               perr_d = 1'b0;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cur_q  <= '0;
      cs_q   <= '0;
      sclk_q <= 1'b0;
      edge_q <= '0;
      cnt_q  <= '0;
      perr_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cur_q  <= cur_d;
      cs_q   <= cs_d;
      sclk_q <= sclk_d;
      edge_q <= edge_d;
      cnt_q  <= cnt_d;
      perr_q <= perr_d;
    end
  end

  assign sel_on  = (st_q == ST_SETUP) || (st_q == ST_XFER) || (st_q == ST_HOLD);
  assign sclk    = sclk_q;
  assign busy    = st_q != ST_IDLE;
  assign done    = st_q == ST_FIN;
  assign par_err = perr_q;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n[g] = ~(sel_on && (cs_q == CSEL_W'(g)));
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (&cs_n));

  // R9
  cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);

  // R11
  ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(cs_q) && $stable(cur_q)));

  // R3
  sclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_XFER) && !tick) |=> $stable(sclk));

  // R7
  par_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err && !par_err_clr) |=> par_err);

endmodule

// File: tb/test_spi_fmt_master.sv
module test_spi_fmt_master;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fmt_wr = 1'b0;
  logic [1:0]  fmt_wr_idx = '0;
  logic [17:0] fmt_wr_data = '0;
  logic        dly_wr = 1'b0;
  logic [15:0] dly_wr_data = '0;
  logic        start = 1'b0;
  logic [1:0]  start_fmt = '0;
  logic [2:0]  start_cs = '0;
  logic [15:0] tx_data = '0;
  logic        miso_r = 1'b0;
  logic        par_err_clr = 1'b0;
  logic        sclk, mosi, busy, done, par_err;
  logic [5:0]  cs_n;
  logic [15:0] rx_data;

  spi_fmt_master i_spi_fmt_master (
    .clk(clk), .rst_n(rst_n), .fmt_wr(fmt_wr), .fmt_wr_idx(fmt_wr_idx),
    .fmt_wr_data(fmt_wr_data), .dly_wr(dly_wr), .dly_wr_data(dly_wr_data),
    .start(start), .start_fmt(start_fmt), .start_cs(start_cs), .tx_data(tx_data),
    .miso(miso_r), .par_err_clr(par_err_clr), .sclk(sclk), .mosi(mosi),
    .cs_n(cs_n), .busy(busy), .done(done), .rx_data(rx_data), .par_err(par_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Bench-side copy of what was programmed
  int m_div [4];
  int m_len [4];
  bit m_ph [4], m_po [4], m_pe [4], m_su [4], m_ho [4], m_lsb [4];
  int m_s = 0, m_h = 0;

  // Slave model
  logic [16:0] sb = '0;
  logic [16:0] mcap = '0;
  int  ec = 0, mk = 0;
  bit  active = 1'b0, cur_ph = 1'b0, half_bad = 1'b0;
  longint half_exp = 0;
  time t_last = 0;

  always @(sclk) begin
    if (active) begin
      int idx;
      if (ec > 0 && longint'($time - t_last) != half_exp) half_bad = 1'b1;
      t_last = $time;
      if ((!cur_ph && ec % 2 == 0) || (cur_ph && ec % 2 == 1)) begin
        if (mk < 17) mcap[mk] = mosi;
        mk++;
      end
      ec++;
      idx = cur_ph ? (ec - 1) / 2 : ec / 2;
      if (idx > 16) idx = 16;
      miso_r = sb[idx];
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic wr_fmt(input int idx, input int dv, input int lf, input bit ph,
                        input bit po, input bit pe, input bit su, input bit ho,
                        input bit lsb);
    @(negedge clk);
    fmt_wr = 1'b1;
    fmt_wr_idx = 2'(idx);
    fmt_wr_data = {lsb, ho, su, pe, po, ph, 4'(lf), 8'(dv)};
    @(negedge clk);
    fmt_wr = 1'b0;
    m_div[idx] = dv;
    m_len[idx] = (lf == 0) ? 2 : lf + 1;
    m_ph[idx] = ph; m_po[idx] = po; m_pe[idx] = pe;
    m_su[idx] = su; m_ho[idx] = ho; m_lsb[idx] = lsb;
  endtask

  task automatic wr_dly(input int s, input int h);
    @(negedge clk);
    dly_wr = 1'b1;
    dly_wr_data = {8'(h), 8'(s)};
    @(negedge clk);
    dly_wr = 1'b0;
    m_s = s; m_h = h;
  endtask

  task automatic clr_err();
    @(negedge clk);
    par_err_clr = 1'b1;
    @(negedge clk);
    par_err_clr = 1'b0;
    chk(par_err == 1'b0, "R7", "flag cleared", par_err, 0);
  endtask

  function automatic logic [5:0] exp_cs(input int cs);
    return (cs < 6) ? ~(6'b1 << cs) : 6'h3F;
  endfunction

  task automatic run_xfer(input int fi, input int cs, input logic [15:0] tx,
                          input logic [15:0] sw, input bit corrupt, input bit poke,
                          input string tag);
    int L, n, S, H, exp_dur, t0, guard;
    logic [15:0] mask;
    logic [16:0] em, nmask;
    bit prev_err, perr_exp;
    L = m_len[fi];
    n = L + int'(m_pe[fi]);
    mask = (L == 16) ? 16'hFFFF : 16'((1 << L) - 1);
    nmask = 17'((1 << n) - 1);
    em = '0;
    sb = '0;
    for (int k = 0; k < L; k++) begin
      em[k] = m_lsb[fi] ? tx[k] : tx[L-1-k];
      sb[k] = m_lsb[fi] ? sw[k] : sw[L-1-k];
    end
    em[L] = ^(tx & mask);
    sb[L] = (^(sw & mask)) ^ corrupt;
    S = (m_su[fi] && m_s != 0) ? m_s : 0;
    H = (m_ho[fi] && m_h != 0) ? m_h : 0;
    exp_dur = S + 2 * n * (m_div[fi] + 1) + H;
    perr_exp = corrupt && m_pe[fi];
    prev_err = par_err;

    cur_ph = m_ph[fi]; ec = 0; mk = 0; half_bad = 1'b0; mcap = '0;
    half_exp = longint'((m_div[fi] + 1) * CLK_PERIOD);
    miso_r = sb[0];

    @(negedge clk);
    start = 1'b1; start_fmt = 2'(fi); start_cs = 3'(cs); tx_data = tx;
    @(negedge clk);
    start = 1'b0; t0 = cyc; active = 1'b1;
    chk(sclk == m_po[fi], "R3", "sclk at polarity before first edge", sclk, m_po[fi]);
    chk(cs_n == exp_cs(cs), "R9", "select asserted", cs_n, exp_cs(cs));
    chk(busy == 1'b1, "R10", "busy after start", busy, 1);
    if (poke) begin
      @(negedge clk);
      start = 1'b1; start_fmt = 2'(fi ^ 1); start_cs = 3'((cs + 1) % 6); tx_data = ~tx;
      @(negedge clk);
      start = 1'b0;
      chk(cs_n == exp_cs(cs), "R11", "select kept during busy start", cs_n, exp_cs(cs));
    end
    guard = 0;
    while (done !== 1'b1 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    chk(done == 1'b1, "R10", "done seen", done, 1);
    chk(cyc - t0 == exp_dur, "R8", "start to done cycles", cyc - t0, exp_dur);
    chk(rx_data == (sw & mask), tag, "received word", rx_data, sw & mask);
    chk(mk == n && ((mcap ^ em) & nmask) == '0, "R5", "sent bit stream",
        mcap & nmask, em & nmask);
    chk(ec == 2 * n, "R3", "sclk edge count", ec, 2 * n);
    chk(!half_bad, "R3", "half period length", half_bad, 0);
    chk(&cs_n, "R9", "selects released at done", cs_n, 6'h3F);
    chk(sclk == m_po[fi], "R3", "sclk idle after last edge", sclk, m_po[fi]);
    active = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R10", "done one cycle", done, 0);
    chk(busy == 1'b0, "R10", "busy low after done", busy, 0);
    chk(par_err == (prev_err | perr_exp), "R7", "parity flag", par_err,
        prev_err | perr_exp);
  endtask

  function automatic int len_of(input int li);
    case (li)
      0: return 2;
      1: return 3;
      2: return 8;
      3: return 15;
      default: return 16;
    endcase
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    int it;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sclk == 1'b0, "R1", "sclk reset", sclk, 0);
    chk(cs_n == 6'h3F, "R1", "cs_n reset", cs_n, 6'h3F);
    chk(!busy && !done, "R1", "busy/done reset", {busy, done}, 0);
    chk(par_err == 1'b0, "R1", "par_err reset", par_err, 0);
    chk(rx_data == '0, "R1", "rx_data reset", rx_data, 0);
    rst_n = 1'b1;

    // R2: four distinct slots, then used without rewriting
    wr_dly(2, 3);
    wr_fmt(0, 1, 7,  0, 0, 1, 1, 1, 0);
    wr_fmt(1, 0, 4,  1, 1, 0, 0, 1, 1);
    wr_fmt(2, 2, 15, 0, 1, 1, 1, 0, 1);
    wr_fmt(3, 0, 1,  1, 0, 0, 1, 1, 0);
    for (int f = 0; f < 4; f++) begin
      run_xfer(f, f, 16'hA5C3 + 16'(f * 331), 16'h3C96 ^ 16'(f * 1201), 1'b0, 1'b0, "R2");
    end

    // R4: length field zero acts as length 2
    wr_fmt(0, 0, 0, 0, 0, 0, 0, 0, 0);
    run_xfer(0, 1, 16'hFFFE, 16'hFFFD, 1'b0, 1'b0, "R4");

    // R7: error is sticky across a clean transfer, then cleared
    wr_fmt(1, 1, 9, 1, 0, 1, 0, 0, 0);
    run_xfer(1, 2, 16'h0155, 16'h02AA, 1'b1, 1'b0, "R7");
    run_xfer(1, 2, 16'h0123, 16'h0321, 1'b0, 1'b0, "R7");
    clr_err();

    // R11: start while busy is ignored
    wr_fmt(2, 3, 11, 0, 1, 1, 1, 1, 1);
    run_xfer(2, 4, 16'h0ABC, 16'h0CBA, 1'b0, 1'b1, "R11");

    // Sweep: mode, order, length, parity, divider, select, delays
    it = 0;
    for (int pm = 0; pm < 4; pm++)
      for (int lsb = 0; lsb < 2; lsb++)
        for (int li = 0; li < 5; li++)
          for (int pe = 0; pe < 2; pe++)
            for (int dv = 0; dv < 3; dv++) begin
              int fi, dvv;
              fi = it % 4;
              dvv = (dv == 2) ? 3 : dv;
              if (it % 40 == 0) wr_dly(it % 5, (it / 40) % 4);
              wr_fmt(fi, dvv, len_of(li) - 1, pm[0], pm[1], pe[0],
                     (it % 3) != 0, (it % 4) < 2, lsb[0]);
              run_xfer(fi, it % 8, 16'(it * 40503) ^ 16'h5A5A, 16'(it * 15467 + 7),
                       (it % 3) == 1, (it % 17) == 0, (lsb == 0) ? "R6" : "R5");
              if (par_err) clr_err();
              it++;
            end

    finish_run();
  end
endmodule